// File: doc/BRIEF.md
# RGMII to GMII Bridge

This block sits between an 8-bit single-rate byte interface on the MAC side and a 4-bit double-data-rate reduced interface on the PHY side. On the receive side it captures a nibble and the control line on every clock edge, then rebuilds one byte with its valid and error flags on each rising edge. On the transmit side it takes one byte, an enable and an error flag per rising edge and sends them as two nibbles and two control levels, one per clock half. The same logic serves the 125 MHz, 25 MHz and 2.5 MHz line rates. Only the clock frequency changes.

The control line does not carry the error flag directly. On the rising edge it carries the valid/enable flag. On the falling edge it carries that flag XOR the error flag. The receive side therefore decodes the error as the XOR of its two control samples, and the transmit side encodes it the same way. Both byte streams are plain valid-qualified streams with no ready signal. The line cannot be stalled, so the consumer must accept a byte on every cycle in which it is offered. Each direction has its own clock and its own active-low asynchronous reset.

Top module: `rgmii_gmii_bridge`

## Requirements
- R1: Receive: the nibble sampled on a rising edge becomes bits 3:0 of the output byte, and the nibble sampled on the following falling edge becomes bits 7:4.
- R2: Receive: the output valid equals the control level sampled on the rising edge.
- R3: Receive: when the rising control sample is 1 and the falling control sample is 0, the byte is output with valid 1 and error 1. When both samples are 1, the error is 0.
- R4: Receive: when both control samples are 0, valid and error are both driven 0 (idle).
- R5: Receive: the byte, valid and error captured across one rising/falling edge pair appear together after the next rising edge, which is one cycle of latency, and hold for one full cycle.
- R6: Transmit: after the rising edge that captures the input byte, the line carries bits 3:0 and the control line carries the enable while the clock is high.
- R7: Transmit: while the clock is low after that edge, the line carries bits 7:4 and the control line carries enable XOR error.
- R8: While its reset is asserted, each direction drives all its outputs to 0.
- R9: Receive: when the rising control sample is 0 and the falling control sample is 1, the output shows valid 0 and error 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive line clock; both edges are used |
| rx_rst_n | input | 1 | Active-low asynchronous reset, receive side |
| rgmii_rxd | input | 4 | Receive nibble from the PHY |
| rgmii_rx_ctl | input | 1 | Receive control line from the PHY |
| gmii_rxd | output | 8 | Rebuilt receive byte |
| gmii_rx_dv | output | 1 | Receive byte valid |
| gmii_rx_er | output | 1 | Receive error flag |
| tx_clk | input | 1 | Transmit line clock; both edges are used |
| tx_rst_n | input | 1 | Active-low asynchronous reset, transmit side |
| gmii_txd | input | 8 | Transmit byte from the MAC |
| gmii_tx_en | input | 1 | Transmit byte enable |
| gmii_tx_er | input | 1 | Transmit error flag |
| rgmii_txd | output | 4 | Transmit nibble to the PHY |
| rgmii_tx_ctl | output | 1 | Transmit control line to the PHY |

## Verification
A wrong falling-edge capture state shows up at the receive outputs one rising edge later. It appears as a swapped or stale high nibble, or as an error flag that does not match the control pair that was driven. A fault in the transmit negative-edge stage is visible in the very next low clock phase. The bench checks the line there, half a cycle after the rising edge that loaded the byte. Every received byte, idle or not, is predicted from the driven pair of line samples and compared exactly one cycle after its falling edge. A dropped, duplicated or shifted byte therefore fails at once.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  // Error recovery: the falling-edge control level is valid XOR error.
  function automatic logic recover_err(logic rise_lvl, logic fall_lvl);
    return rise_lvl ^ fall_lvl;
  endfunction

  // Encoding of the falling-edge control level on transmit.
  function automatic logic fold_ctl(logic en, logic er);
    return en ^ er;
  endfunction

endpackage

// File: rtl/bridge_ddr_in.sv
module bridge_ddr_in #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q
);

  // One rising and one falling capture flop per line.
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rise_q[b] <= 1'b0;
      else        rise_q[b] <= din[b];
    end

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) fall_q[b] <= 1'b0;
      else        fall_q[b] <= din[b];
    end
  end

endmodule

// File: rtl/bridge_rx_assemble.sv
module bridge_rx_assemble #(
  parameter int NIBBLE_W = 4,
  localparam int BYTE_W = 2 * NIBBLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NIBBLE_W-1:0] lo_nib,
  input  logic [NIBBLE_W-1:0] hi_nib,
  input  logic                ctl_rise,
  input  logic                ctl_fall,
  output logic [BYTE_W-1:0]   byte_o,
  output logic                dv_o,
  output logic                er_o
);
  import bridge_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_o <= '0;
      dv_o   <= 1'b0;
      er_o   <= 1'b0;
    end else begin
      byte_o <= {hi_nib, lo_nib};
      dv_o   <= ctl_rise;
      er_o   <= recover_err(ctl_rise, ctl_fall);
    end
  end

  // R4
  idle_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rise && !ctl_fall) |=> (!dv_o && !er_o));

  // R3
  err_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rise && !ctl_fall) |=> (dv_o && er_o));

  // R9
  carrier_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rise && ctl_fall) |=> (!dv_o && er_o));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rise && ctl_fall) |=> (dv_o && !er_o));

endmodule

// File: rtl/bridge_tx_stage.sv
module bridge_tx_stage #(
  parameter int NIBBLE_W = 4,
  localparam int BYTE_W = 2 * NIBBLE_W,
  localparam int WORD_W = NIBBLE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              en_i,
  input  logic              er_i,
  output logic [WORD_W-1:0] pos_word,
  output logic [WORD_W-1:0] neg_word
);
  import bridge_pkg::*;

  logic [NIBBLE_W-1:0] lo_q, hi_q;
  logic                en_q, er_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      en_q <= 1'b0;
      er_q <= 1'b0;
    end else begin
      lo_q <= byte_i[NIBBLE_W-1:0];
      hi_q <= byte_i[BYTE_W-1:NIBBLE_W];
      en_q <= en_i;
      er_q <= er_i;
    end
  end

  assign pos_word = {en_q, lo_q};
  assign neg_word = {fold_ctl(en_q, er_q), hi_q};

endmodule

// File: rtl/bridge_ddr_out.sv
module bridge_ddr_out #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pos_d,
  input  logic [W-1:0] neg_d,
  output logic [W-1:0] line_o
);

  logic [W-1:0] neg_q;

  // Per line: falling-edge hold flop and a clock-phase select.
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) neg_q[b] <= 1'b0;
      else        neg_q[b] <= neg_d[b];
    end
    assign line_o[b] = clk ? pos_d[b] : neg_q[b];
  end

  // R7
  low_phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    neg_q == neg_d);

endmodule

// File: rtl/rgmii_gmii_bridge.sv
module rgmii_gmii_bridge #(
  parameter int NIBBLE_W = 4,
  localparam int BYTE_W = 2 * NIBBLE_W,
  localparam int LANE_W = NIBBLE_W + 1
) (
  input  logic                rx_clk,
  input  logic                rx_rst_n,
  input  logic [NIBBLE_W-1:0] rgmii_rxd,
  input  logic                rgmii_rx_ctl,
  output logic [BYTE_W-1:0]   gmii_rxd,
  output logic                gmii_rx_dv,
  output logic                gmii_rx_er,
  input  logic                tx_clk,
  input  logic                tx_rst_n,
  input  logic [BYTE_W-1:0]   gmii_txd,
  input  logic                gmii_tx_en,
  input  logic                gmii_tx_er,
  output logic [NIBBLE_W-1:0] rgmii_txd,
  output logic                rgmii_tx_ctl
);

  logic [LANE_W-1:0] rx_rise, rx_fall;

  bridge_ddr_in #(.W(LANE_W)) u_rx_cap (
    .clk    (rx_clk),
    .rst_n  (rx_rst_n),
    .din    ({rgmii_rx_ctl, rgmii_rxd}),
    .rise_q (rx_rise),
    .fall_q (rx_fall)
  );

  bridge_rx_assemble #(.NIBBLE_W(NIBBLE_W)) u_rx_asm (
    .clk      (rx_clk),
    .rst_n    (rx_rst_n),
    .lo_nib   (rx_rise[NIBBLE_W-1:0]),
    .hi_nib   (rx_fall[NIBBLE_W-1:0]),
    .ctl_rise (rx_rise[LANE_W-1]),
    .ctl_fall (rx_fall[LANE_W-1]),
    .byte_o   (gmii_rxd),
    .dv_o     (gmii_rx_dv),
    .er_o     (gmii_rx_er)
  );

  logic [LANE_W-1:0] tx_pos, tx_neg, tx_line;

  bridge_tx_stage #(.NIBBLE_W(NIBBLE_W)) u_tx_stage (
    .clk      (tx_clk),
    .rst_n    (tx_rst_n),
    .byte_i   (gmii_txd),
    .en_i     (gmii_tx_en),
    .er_i     (gmii_tx_er),
    .pos_word (tx_pos),
    .neg_word (tx_neg)
  );

  bridge_ddr_out #(.W(LANE_W)) u_tx_launch (
    .clk    (tx_clk),
    .rst_n  (tx_rst_n),
    .pos_d  (tx_pos),
    .neg_d  (tx_neg),
    .line_o (tx_line)
  );

  assign rgmii_txd    = tx_line[NIBBLE_W-1:0];
  assign rgmii_tx_ctl = tx_line[LANE_W-1];

  // R6
  tx_rise_enable_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    gmii_tx_en |=> tx_pos[LANE_W-1]);

endmodule

// File: tb/rgmii_gmii_bridge_test.sv
module rgmii_gmii_bridge_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rxd = '0;
  logic       rx_ctl = 1'b0;
  logic [7:0] gm_rxd;
  logic       gm_dv, gm_er;
  logic [7:0] txd = '0;
  logic       tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0] line_txd;
  logic       line_txctl;

  always #4 clk = ~clk;

  rgmii_gmii_bridge uut (
    .rx_clk(clk), .rx_rst_n(rst_n), .rgmii_rxd(rxd), .rgmii_rx_ctl(rx_ctl),
    .gmii_rxd(gm_rxd), .gmii_rx_dv(gm_dv), .gmii_rx_er(gm_er),
    .tx_clk(clk), .tx_rst_n(rst_n), .gmii_txd(txd), .gmii_tx_en(tx_en),
    .gmii_tx_er(tx_er), .rgmii_txd(line_txd), .rgmii_tx_ctl(line_txctl)
  );

  typedef struct {
    logic [7:0] d;
    logic       dv;
    logic       er;
    int         due;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  int ncnt   = 0;
  bit done   = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops expected receive bytes when they fall due.
  always @(negedge clk) begin
    ncnt++;
    if (q.size() > 0 && q[0].due == ncnt) begin
      exp_t e;
      e = q.pop_front();
      chk({e.req, " R1 byte"}, {24'd0, gm_rxd}, {24'd0, e.d});
      chk({e.req, " R2 valid"}, {31'd0, gm_dv}, {31'd0, e.dv});
      chk({e.req, " R5 error"}, {31'd0, gm_er}, {31'd0, e.er});
    end
  end

  // Driver: one byte across a rising/falling edge pair.
  task automatic rx_send(logic [7:0] d, logic ctl_r, logic ctl_f, logic exp_dv,
                         logic exp_er, string req);
    exp_t e;
    @(negedge clk);
    #2;
    rxd    = d[3:0];
    rx_ctl = ctl_r;
    e.d = d; e.dv = exp_dv; e.er = exp_er; e.due = ncnt + 2; e.req = req;
    q.push_back(e);
    @(posedge clk);
    #2;
    rxd    = d[7:4];
    rx_ctl = ctl_f;
  endtask

  task automatic tx_send(logic [7:0] d, logic en, logic er);
    txd = d; tx_en = en; tx_er = er;
    @(posedge clk);
    #2;
    chk("R6 low nibble", {28'd0, line_txd}, {28'd0, d[3:0]});
    chk("R6 enable level", {31'd0, line_txctl}, {31'd0, en});
    @(negedge clk);
    #2;
    chk("R7 high nibble", {28'd0, line_txd}, {28'd0, d[7:4]});
    chk("R7 folded control", {31'd0, line_txctl}, {31'd0, en ^ er});
  endtask

  initial begin
    #(50000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state on both directions, in the high phase
    chk("R8 rx byte", {24'd0, gm_rxd}, 32'd0);
    chk("R8 rx valid", {31'd0, gm_dv}, 32'd0);
    chk("R8 rx error", {31'd0, gm_er}, 32'd0);
    chk("R8 tx line", {27'd0, line_txctl, line_txd}, 32'd0);
    @(negedge clk);
    #1;
    chk("R8 tx line low phase", {27'd0, line_txctl, line_txd}, 32'd0);
    rst_n = 1'b1;

    // R4 idle bytes
    for (int i = 0; i < 3; i++) rx_send(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R4 idle");
    // R1 R2 R5 a clean frame with varied nibbles
    rx_send(8'h55, 1'b1, 1'b1, 1'b1, 1'b0, "R3 clean");
    rx_send(8'hD5, 1'b1, 1'b1, 1'b1, 1'b0, "R3 clean");
    rx_send(8'hA5, 1'b1, 1'b1, 1'b1, 1'b0, "R1 nibble order");
    rx_send(8'h0F, 1'b1, 1'b1, 1'b1, 1'b0, "R1 nibble order");
    rx_send(8'hF0, 1'b1, 1'b1, 1'b1, 1'b0, "R1 nibble order");
    // R3 error inside the frame
    rx_send(8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, "R3 error");
    rx_send(8'hC3, 1'b1, 1'b1, 1'b1, 1'b0, "R3 error cleared");
    rx_send(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R4 idle after frame");
    // R9 control high only on the falling edge
    rx_send(8'h0E, 1'b0, 1'b1, 1'b0, 1'b1, "R9 carrier only");
    rx_send(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R4 idle");
    rx_send(8'h12, 1'b1, 1'b1, 1'b1, 1'b0, "R5 single byte");
    rx_send(8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, "R3 error all ones");
    for (int i = 0; i < 3; i++) rx_send(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R4 idle tail");
    repeat (4) @(negedge clk);
    #2;
    chk("R5 all received bytes observed", q.size(), 32'd0);

    // Transmit direction
    tx_send(8'h00, 1'b0, 1'b0);
    tx_send(8'h55, 1'b1, 1'b0);
    tx_send(8'hD5, 1'b1, 1'b0);
    tx_send(8'h9A, 1'b1, 1'b1);
    tx_send(8'hF0, 1'b1, 1'b0);
    tx_send(8'h0F, 1'b0, 1'b1);
    tx_send(8'hFF, 1'b0, 1'b0);
    tx_send(8'h00, 1'b0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule